// File: doc/BRIEF.md
# Low-Power Wake-Up Event Manager

This block watches a set of wake sources while the device sits in a low-power mode and raises one wake request when a qualified event arrives. It covers sixteen general-purpose pins (two 8-bit ports), four monitor inputs, the active-low hardware reset pin, a LIN wake pulse, an external-supply fail flag and a high-side overtemperature flag. Each source is admitted only in the power modes where it may wake the device. Each qualified event sets its own sticky bit in a status register. The wake request is the OR of those bits.

Software configures the per-pin edge polarity through a small word-addressed register bus. It reads the status register to find the cause of a wake, and clears bits by writing ones to them. A separate configuration word holds the two high-side cyclic-sense enable bits, and these drive output pins directly. The mode input is sampled on every clock. All inputs are taken as already synchronized to the clock.

Top module: `wake_mgr`

## Requirements
- R1: After synchronous reset, every register reads 0, `wake_req` is 0 and both cyclic-sense outputs are 0.
- R2: General-purpose pin i of port 0 uses enable bit i, and pin i of port 1 uses enable bit 8+i. The enables live in the rising-edge word (address 1) and the falling-edge word (address 2). Setting both bits wakes on either edge. An enabled edge sets status bit i (port 0) or 8+i (port 1). An edge is the input compared against its value on the previous clock.
- R3: Pin events are accepted only in modes Stop (mode code 1) and Stop with cyclic sense (code 2). They are ignored in Sleep (3), Sleep with cyclic sense (4) and Run (0).
- R4: Monitor input k has a rising enable at bit k and a falling enable at bit 4+k of address 3. An enabled edge sets status bit 16+k in any of modes 1 to 4.
- R5: A falling edge on the reset pin sets status bit 20 in modes 1 and 2 only.
- R6: A high level on the LIN wake input sets status bit 21 in any of modes 1 to 4. It has no enable bit.
- R7: A high supply-fail flag sets status bit 22 in modes 1 and 2 only. A high overtemperature flag sets status bit 23 in any of modes 1 to 4.
- R8: In Run mode no status bit is set, whatever the inputs do.
- R9: The status register is at address 0. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. `wake_req` equals the OR of the status bits. It goes high on the clock edge that captures the event.
- R10: If an event and a clearing write to its bit land on the same clock edge, the bit stays set.
- R11: A status bit stays set when the mode changes, including to a mode where its source is not accepted.
- R12: Address 4 is a 32-bit configuration word. Bit 2 drives `hs1_cyc_en` and bit 10 drives `hs2_cyc_en`. All other bits read 0 and ignore writes. Read data appears on `bus_rdata` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Power mode: 0 Run, 1 Stop, 2 Stop cyclic, 3 Sleep, 4 Sleep cyclic |
| gpio_p0 | input | 8 | Port 0 pin levels |
| gpio_p1 | input | 8 | Port 1 pin levels |
| mon_in | input | 4 | Monitor input levels |
| rst_pin_n | input | 1 | Hardware reset pin level, active low |
| lin_wake | input | 1 | LIN wake pulse |
| vext_fail | input | 1 | External supply fail flag |
| hs_ot | input | 1 | High-side overtemperature flag |
| bus_addr | input | 3 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| wake_req | output | 1 | Wake request to the power sequencer |
| hs1_cyc_en | output | 1 | High-side switch 1 cyclic-sense enable |
| hs2_cyc_en | output | 1 | High-side switch 2 cyclic-sense enable |

## Verification
The bench tests mode gating on each source: a pin edge in Sleep, a reset-pin fall in Sleep, a supply-fail flag in Sleep, and every source in Run. A design that gated on "any low-power mode" would latch wakes there that must not occur. It tests polarity by pairing rising-only, falling-only and both-edge pins. A swapped enable word or a wrong bit index would set the wrong status bit or none. It tests a clearing write that coincides with a held LIN event. A design that let the clear win would lose the wake. It also tests a mode change after a bit is latched, where a design that re-qualified stored bits would drop the request. Finally, it writes all ones to the configuration word to expose reserved bits that do not read back as zero.

// File: rtl/wake_pkg.sv
package wake_pkg;
  typedef enum logic [2:0] {
    PM_RUN      = 3'd0,
    PM_STOP     = 3'd1,
    PM_STOP_CS  = 3'd2,
    PM_SLEEP    = 3'd3,
    PM_SLEEP_CS = 3'd4
  } pm_e;

  localparam int unsigned A_STAT  = 0;
  localparam int unsigned A_RISE  = 1;
  localparam int unsigned A_FALL  = 2;
  localparam int unsigned A_MON   = 3;
  localparam int unsigned A_CFG   = 4;
  localparam int unsigned HS1_BIT = 2;
  localparam int unsigned HS2_BIT = 10;

  function automatic logic is_stop(input logic [2:0] m);
    return (m == PM_STOP) || (m == PM_STOP_CS);
  endfunction

  function automatic logic is_sleep(input logic [2:0] m);
    return (m == PM_SLEEP) || (m == PM_SLEEP_CS);
  endfunction
endpackage

// File: rtl/wake_edge_det.sv
module wake_edge_det #(
  parameter int unsigned W       = 8,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  output logic [W-1:0] evt
);
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= {W{RST_VAL}};
    else     prev <= din;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign evt[i] = (rise_en[i] & din[i] & ~prev[i]) |
                    (fall_en[i] & ~din[i] & prev[i]);
  end
endmodule

// File: rtl/wake_qualify.sv
module wake_qualify
  import wake_pkg::*;
#(
  parameter int unsigned GP_W  = 16,
  parameter int unsigned MON_N = 4,
  localparam int unsigned ST_W = GP_W + MON_N + 4
) (
  input  logic [2:0]       mode,
  input  logic [GP_W-1:0]  gpio_evt,
  input  logic [MON_N-1:0] mon_evt,
  input  logic             rpin_evt,
  input  logic             lin_lvl,
  input  logic             vfail_lvl,
  input  logic             ot_lvl,
  output logic [ST_W-1:0]  evt
);
  logic stop_ok, any_ok;

  always_comb begin
    stop_ok = is_stop(mode);
    any_ok  = stop_ok | is_sleep(mode);
    evt = {ot_lvl & any_ok,
           vfail_lvl & stop_ok,
           lin_lvl & any_ok,
           rpin_evt & stop_ok,
           mon_evt & {MON_N{any_ok}},
           gpio_evt & {GP_W{stop_ok}}};
  end
endmodule

// File: rtl/wake_regs.sv
module wake_regs
  import wake_pkg::*;
#(
  parameter int unsigned GP_W  = 16,
  parameter int unsigned MON_N = 4,
  parameter int unsigned AW    = 3,
  parameter int unsigned DW    = 32,
  localparam int unsigned ST_W = GP_W + MON_N + 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ST_W-1:0]    evt,
  input  logic [AW-1:0]      bus_addr,
  input  logic               bus_wr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  output logic [GP_W-1:0]    gpio_rise,
  output logic [GP_W-1:0]    gpio_fall,
  output logic [2*MON_N-1:0] mon_cfg,
  output logic               hs1,
  output logic               hs2,
  output logic [ST_W-1:0]    status,
  output logic               wake_req
);
  logic [ST_W-1:0] clr, status_nxt;
  logic [DW-1:0]   rd_mux;

  always_comb begin
    clr = '0;
    if (bus_wr && bus_addr == AW'(A_STAT)) clr = bus_wdata[ST_W-1:0];
    status_nxt = (status & ~clr) | evt;
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      AW'(A_STAT): rd_mux[ST_W-1:0]    = status;
      AW'(A_RISE): rd_mux[GP_W-1:0]    = gpio_rise;
      AW'(A_FALL): rd_mux[GP_W-1:0]    = gpio_fall;
      AW'(A_MON):  rd_mux[2*MON_N-1:0] = mon_cfg;
      AW'(A_CFG): begin
        rd_mux[HS1_BIT] = hs1;
        rd_mux[HS2_BIT] = hs2;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gpio_rise <= '0;
      gpio_fall <= '0;
      mon_cfg   <= '0;
      hs1       <= 1'b0;
      hs2       <= 1'b0;
      status    <= '0;
      wake_req  <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          AW'(A_RISE): gpio_rise <= bus_wdata[GP_W-1:0];
          AW'(A_FALL): gpio_fall <= bus_wdata[GP_W-1:0];
          AW'(A_MON):  mon_cfg   <= bus_wdata[2*MON_N-1:0];
          AW'(A_CFG): begin
            hs1 <= bus_wdata[HS1_BIT];
            hs2 <= bus_wdata[HS2_BIT];
          end
          default: ;
        endcase
      end
      status    <= status_nxt;
      wake_req  <= |status_nxt;
      bus_rdata <= rd_mux;
    end
  end

  // R11: bits only drop through a clearing write
  a_r11_bits_hold: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == AW'(A_STAT)) |=> ((status & $past(status)) == $past(status)));

  // R10: an event always lands, even against a clearing write
  a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> ((status & $past(evt)) == $past(evt)));

  // R9: the request only rises after a qualified event
  a_r9_req_source: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_req) |-> $past(|evt));

  // R12: cyclic-sense outputs move only on a write to the config word
  a_r12_cfg_stable: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == AW'(A_CFG)) |=> $stable({hs1, hs2}));
endmodule

// File: rtl/wake_mgr.sv
module wake_mgr
  import wake_pkg::*;
#(
  parameter int unsigned PORT_W = 8,
  parameter int unsigned MON_N  = 4,
  parameter int unsigned AW     = 3,
  parameter int unsigned DW     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        mode,
  input  logic [PORT_W-1:0] gpio_p0,
  input  logic [PORT_W-1:0] gpio_p1,
  input  logic [MON_N-1:0]  mon_in,
  input  logic              rst_pin_n,
  input  logic              lin_wake,
  input  logic              vext_fail,
  input  logic              hs_ot,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              wake_req,
  output logic              hs1_cyc_en,
  output logic              hs2_cyc_en
);
  localparam int unsigned GP_W = 2 * PORT_W;
  localparam int unsigned ST_W = GP_W + MON_N + 4;

  logic [GP_W-1:0]    gpio_rise, gpio_fall, gpio_evt;
  logic [2*MON_N-1:0] mon_cfg;
  logic [MON_N-1:0]   mon_evt;
  logic               rpin_evt;
  logic [ST_W-1:0]    evt, status;

  wake_edge_det #(.W(GP_W), .RST_VAL(1'b0)) u_gpio_edge (
    .clk(clk), .rst(rst), .din({gpio_p1, gpio_p0}),
    .rise_en(gpio_rise), .fall_en(gpio_fall), .evt(gpio_evt));

  wake_edge_det #(.W(MON_N), .RST_VAL(1'b0)) u_mon_edge (
    .clk(clk), .rst(rst), .din(mon_in),
    .rise_en(mon_cfg[MON_N-1:0]), .fall_en(mon_cfg[2*MON_N-1:MON_N]), .evt(mon_evt));

  wake_edge_det #(.W(1), .RST_VAL(1'b1)) u_rpin_edge (
    .clk(clk), .rst(rst), .din(rst_pin_n),
    .rise_en(1'b0), .fall_en(1'b1), .evt(rpin_evt));

  wake_qualify #(.GP_W(GP_W), .MON_N(MON_N)) u_qual (
    .mode(mode), .gpio_evt(gpio_evt), .mon_evt(mon_evt), .rpin_evt(rpin_evt),
    .lin_lvl(lin_wake), .vfail_lvl(vext_fail), .ot_lvl(hs_ot), .evt(evt));

  wake_regs #(.GP_W(GP_W), .MON_N(MON_N), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .evt(evt),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .gpio_rise(gpio_rise), .gpio_fall(gpio_fall), .mon_cfg(mon_cfg),
    .hs1(hs1_cyc_en), .hs2(hs2_cyc_en), .status(status), .wake_req(wake_req));

  // R8: Run mode never latches a new source
  a_r8_run_quiet: assert property (@(posedge clk) disable iff (rst)
    (mode == PM_RUN) |=> ((status & ~$past(status)) == '0));

  // R3: pin events never latch in either Sleep mode
  a_r3_gpio_sleep: assert property (@(posedge clk) disable iff (rst)
    is_sleep(mode) |=> ((status[GP_W-1:0] & ~$past(status[GP_W-1:0])) == '0));
endmodule

// File: tb/wake_mgr_bench.sv
module wake_mgr_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [2:0]  md;
    logic [15:0] ag;
    logic [3:0]  am;
    logic        ar;
    logic [15:0] bg;
    logic [3:0]  bm;
    logic        br;
    logic        lin;
    logic        vf;
    logic        ot;
    logic [23:0] ex;
  } vec_t;

  // enables used: rise=0x00FF, fall=0xFF01, monitor rise=0011 fall=0110
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{3'd1, 16'h0000, 4'h0, 1'b1, 16'h0004, 4'h0, 1'b1, 1'b0, 1'b0, 1'b0, 24'h000004}, // R2 rise
    '{3'd1, 16'h0100, 4'h0, 1'b1, 16'h0000, 4'h0, 1'b1, 1'b0, 1'b0, 1'b0, 24'h000100}, // R2 port1 fall
    '{3'd1, 16'h0001, 4'h0, 1'b1, 16'h0000, 4'h0, 1'b1, 1'b0, 1'b0, 1'b0, 24'h000001}, // R2 both-edge pin
    '{3'd2, 16'h0000, 4'h0, 1'b1, 16'h0108, 4'h0, 1'b1, 1'b0, 1'b0, 1'b0, 24'h000008}, // R3 stop-cyclic
    '{3'd3, 16'h0000, 4'h0, 1'b1, 16'h00FF, 4'h0, 1'b1, 1'b0, 1'b0, 1'b0, 24'h000000}, // R3 sleep ignored
    '{3'd4, 16'h0000, 4'h0, 1'b1, 16'h0000, 4'h3, 1'b1, 1'b0, 1'b0, 1'b0, 24'h030000}, // R4 rise in sleep
    '{3'd1, 16'h0000, 4'hF, 1'b1, 16'h0000, 4'h0, 1'b1, 1'b0, 1'b0, 1'b0, 24'h060000}, // R4 fall
    '{3'd1, 16'h0000, 4'h0, 1'b1, 16'h0000, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 24'h100000}, // R5 stop
    '{3'd3, 16'h0000, 4'h0, 1'b1, 16'h0000, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 24'h000000}, // R5 sleep
    '{3'd3, 16'h0000, 4'h0, 1'b1, 16'h0000, 4'h0, 1'b1, 1'b1, 1'b0, 1'b0, 24'h200000}, // R6 lin
    '{3'd3, 16'h0000, 4'h0, 1'b1, 16'h0000, 4'h0, 1'b1, 1'b0, 1'b1, 1'b1, 24'h800000}, // R7 sleep
    '{3'd2, 16'h0000, 4'h0, 1'b1, 16'h0000, 4'h0, 1'b1, 1'b0, 1'b1, 1'b0, 24'h400000}, // R7 stop
    '{3'd0, 16'h0000, 4'h0, 1'b1, 16'h00FF, 4'h3, 1'b0, 1'b1, 1'b1, 1'b1, 24'h000000}  // R8 run
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  mode = 3'd0;
  logic [7:0]  gpio_p0 = '0, gpio_p1 = '0;
  logic [3:0]  mon_in = '0;
  logic        rst_pin_n = 1'b1, lin_wake = 1'b0, vext_fail = 1'b0, hs_ot = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wake_req, hs1_cyc_en, hs2_cyc_en;

  int total = 0, bad = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_mgr u_wake_mgr (
    .clk(clk), .rst(rst), .mode(mode), .gpio_p0(gpio_p0), .gpio_p1(gpio_p1),
    .mon_in(mon_in), .rst_pin_n(rst_pin_n), .lin_wake(lin_wake),
    .vext_fail(vext_fail), .hs_ot(hs_ot), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wake_req(wake_req),
    .hs1_cyc_en(hs1_cyc_en), .hs2_cyc_en(hs2_cyc_en));

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    tick();
    d = bus_rdata;
    bus_addr = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] got;
    @(negedge clk);
    tick(); tick();
    rst = 1'b0;
    // R1 reset state
    check("R1 wake_req", {31'b0, wake_req}, 32'h0);
    check("R1 hs outs", {30'b0, hs1_cyc_en, hs2_cyc_en}, 32'h0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), got);
      check($sformatf("R1 reg %0d", a), got, 32'h0);
    end

    wr(3'd1, 32'h0000_00FF);
    wr(3'd2, 32'h0000_FF01);
    wr(3'd3, 32'h0000_0063);
    rd(3'd3, got);
    check("R4 monitor enables readback", got, 32'h63);

    // table walk: R2 R3 R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      mode = VECS[v].md; {gpio_p1, gpio_p0} = VECS[v].ag;
      mon_in = VECS[v].am; rst_pin_n = VECS[v].ar;
      lin_wake = 1'b0; vext_fail = 1'b0; hs_ot = 1'b0;
      tick(); tick();
      wr(3'd0, 32'h00FF_FFFF);
      {gpio_p1, gpio_p0} = VECS[v].bg; mon_in = VECS[v].bm; rst_pin_n = VECS[v].br;
      lin_wake = VECS[v].lin; vext_fail = VECS[v].vf; hs_ot = VECS[v].ot;
      tick();
      lin_wake = 1'b0; vext_fail = 1'b0; hs_ot = 1'b0;
      rd(3'd0, got);
      check($sformatf("vector %0d status", v), got, {8'h0, VECS[v].ex});
      check($sformatf("vector %0d wake_req", v), {31'b0, wake_req}, {31'b0, VECS[v].ex != 0});
    end
    gpio_p0 = '0; gpio_p1 = '0; mon_in = '0; rst_pin_n = 1'b1;

    // R9 timing and write-1-to-clear
    mode = 3'd1;
    tick(); tick();
    wr(3'd0, 32'h00FF_FFFF);
    check("R9 idle wake_req", {31'b0, wake_req}, 32'h0);
    lin_wake = 1'b1;
    tick();
    lin_wake = 1'b0;
    check("R9 wake_req one edge after event", {31'b0, wake_req}, 32'h1);
    gpio_p0 = 8'h04;
    tick();
    wr(3'd0, 32'h0020_0000);
    rd(3'd0, got);
    check("R9 partial clear", got, 32'h0000_0004);
    check("R9 wake_req still set", {31'b0, wake_req}, 32'h1);
    wr(3'd0, 32'h0000_0004);
    rd(3'd0, got);
    check("R9 full clear", got, 32'h0);
    check("R9 wake_req dropped", {31'b0, wake_req}, 32'h0);
    gpio_p0 = '0;
    tick();

    // R10 set beats clear on the same edge
    mode = 3'd3;
    lin_wake = 1'b1;
    tick();
    wr(3'd0, 32'h0020_0000);
    lin_wake = 1'b0;
    rd(3'd0, got);
    check("R10 set wins over clear", got, 32'h0020_0000);
    wr(3'd0, 32'h00FF_FFFF);

    // R11 mode change keeps latched bits
    mode = 3'd1;
    gpio_p0 = 8'h08;
    tick();
    mode = 3'd0;
    tick(); tick();
    mode = 3'd3;
    tick();
    rd(3'd0, got);
    check("R11 bit kept across mode change", got, 32'h0000_0008);
    check("R11 wake_req kept", {31'b0, wake_req}, 32'h1);
    wr(3'd0, 32'h00FF_FFFF);
    gpio_p0 = '0;

    // R12 configuration word
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, got);
    check("R12 reserved bits read 0", got, 32'h0000_0404);
    check("R12 both outputs on", {30'b0, hs1_cyc_en, hs2_cyc_en}, 32'h3);
    wr(3'd4, 32'h0000_0004);
    check("R12 hs2 off hs1 on", {30'b0, hs1_cyc_en, hs2_cyc_en}, 32'h2);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule